// File: doc/BRIEF.md
# Signal-Quality and Loss-of-Signal Interrupt Unit

This block watches the two receive inputs of a serial link receiver and the horizontal eye-opening figure produced by an eye monitor. Each raw signal-detect level is brought into the clock domain, filtered so that short glitches are ignored, and turned into a per-input loss-of-signal status. Software can force either input to read as "no signal", which is how the receive path is shut down while a signal is still present.

The status of whichever input is currently selected drives an automatic power-down request for the clock recovery and output drivers. Two conditions are recorded as sticky interrupt sources: loss of signal on the selected input, and an eye-quality alert. The alert fires when a freshly measured horizontal opening falls below a 4-bit threshold scaled by four. The source bits clear when they are read. An active-low, open-drain-style interrupt pin is pulled low while a global pin enable is set and any source bit is held.

Top module: `link_alert_unit`

## Requirements
- R1: While reset is asserted, losStatus reads 2'b11, rxPowerDown is 1, irqSrc is 2'b00 and irqPinN is 1.
- R2: losStatus bit 0 reports loss on input 0 and bit 1 reports loss on input 1. A new raw level changes the status at the fifth rising edge after the edge that first samples it, provided the level is held for four consecutive synchronized samples. A pulse shorter than four clocks leaves the status unchanged.
- R3: While sdForceOff[i] is 1, losStatus[i] reads 1 whatever the detector sees. Clearing it returns the bit to the filtered detector value in the same cycle.
- R4: rxPowerDown equals the loss status of the input chosen by inSel (0 selects input 0, 1 selects input 1).
- R5: At a rising edge where eyeValid and alertEn are both 1 and eyeWidth is strictly less than eyeThresh*4, irqSrc bit 1 is set. Without eyeValid, without alertEn, or with eyeWidth at or above the scaled threshold, the bit is not set.
- R6: irqSrc bit 0 is set at every rising edge where the selected input shows loss of signal. Both source bits stay set until cleared by a read.
- R7: A srcRead pulse at a rising edge clears both source bits, except that a bit whose set condition holds at that same edge stays set.
- R8: irqPinN is 0 exactly when pinEn is 1 and at least one irqSrc bit is set; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sdRaw | input | 2 | Raw, asynchronous signal-detect levels, one per input (1 = signal present) |
| sdForceOff | input | 2 | Per-input control forcing that input to read as no signal |
| inSel | input | 1 | Selected receive input |
| eyeWidth | input | 8 | Horizontal eye-opening measurement |
| eyeValid | input | 1 | One-cycle strobe marking a new eyeWidth value |
| eyeThresh | input | 4 | Alert threshold, compared after scaling by four |
| alertEn | input | 1 | Enables the eye-quality alert source |
| pinEn | input | 1 | Global enable for driving the interrupt pin |
| srcRead | input | 1 | Read strobe for the interrupt-source register (clear on read) |
| losStatus | output | 2 | Per-input loss-of-signal status |
| rxPowerDown | output | 1 | Power-down request for the receive path |
| irqSrc | output | 2 | Sticky interrupt sources: bit 0 loss of signal on the selected input, bit 1 eye alert |
| irqPinN | output | 1 | Active-low, open-drain-style interrupt pin |

## Verification
The detectors are driven with long steady levels, which separate a correct four-sample filter from an off-by-one latency, and with three-cycle pulses, which show whether the filter passes glitches at all. Forcing an input off while the other one is selected, and then while it is itself selected, tells the status flag apart from the power-down path. Eye measurements are placed one below, exactly at and above the scaled threshold, at both threshold extremes, without the strobe and with the alert disabled, so that a wrong comparison sense, a missing scale or a missing gate each shows as a mismatch. Reads issued while a loss condition persists and after it has gone apart show the set-over-clear priority from a plain clear.

// File: rtl/link_alert_pkg.sv
package link_alert_pkg;
  localparam int NUM_SRC = 2;
  localparam int SRC_LOS = 0;
  localparam int SRC_EYE = 1;

  // Strobes handed from the control half to the source register
  typedef struct packed {
    logic [NUM_SRC-1:0] srcSet;
    logic               srcClear;
  } srcStrobe_t;
endpackage

// File: rtl/sd_filter.sv
module sd_filter #(
  parameter int DEB_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic detOut
);
  localparam int CNT_W = (DEB_LEN > 2) ? $clog2(DEB_LEN) : 1;

  logic [1:0]       syncQ;
  logic [CNT_W-1:0] runCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      runCnt <= '0;
      detOut <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] != detOut) begin
        if (runCnt == CNT_W'(DEB_LEN - 1)) begin
          detOut <= syncQ[1];
          runCnt <= '0;
        end else begin
          runCnt <= runCnt + 1'b1;
        end
      end else begin
        runCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/alert_ctrl.sv
module alert_ctrl
  import link_alert_pkg::*;
#(
  parameter int NUM_IN    = 2,
  parameter int SEL_W     = 1,
  parameter int DEB_LEN   = 4,
  parameter int EYE_W     = 8,
  parameter int THR_W     = 4,
  parameter int THR_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] sdRaw,
  input  logic [NUM_IN-1:0] sdForceOff,
  input  logic [SEL_W-1:0]  inSel,
  input  logic [EYE_W-1:0]  eyeWidth,
  input  logic              eyeValid,
  input  logic [THR_W-1:0]  eyeThresh,
  input  logic              alertEn,
  input  logic              srcRead,
  output logic [NUM_IN-1:0] losStatus,
  output logic              rxPowerDown,
  output srcStrobe_t        strobe
);
  localparam int SCL_W = THR_W + THR_SHIFT;
  localparam int CMP_W = (EYE_W > SCL_W) ? EYE_W : SCL_W;

  logic [NUM_IN-1:0] detQ;
  logic [SCL_W-1:0]  threshScaled;
  logic [CMP_W-1:0]  widthExt;
  logic [CMP_W-1:0]  threshExt;
  logic              selLos;
  logic              eyeLow;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_det
    sd_filter #(.DEB_LEN(DEB_LEN)) u_filt (
      .clk   (clk),
      .rstN  (rstN),
      .rawIn (sdRaw[g]),
      .detOut(detQ[g])
    );
  end

  always_comb begin
    losStatus    = ~detQ | sdForceOff;
    selLos       = losStatus[inSel];
    rxPowerDown  = selLos;
    threshScaled = {eyeThresh, {THR_SHIFT{1'b0}}};
    widthExt     = CMP_W'(eyeWidth);
    threshExt    = CMP_W'(threshScaled);
    eyeLow       = widthExt < threshExt;

    strobe                 = '0;
    strobe.srcSet[SRC_LOS] = selLos;
    strobe.srcSet[SRC_EYE] = eyeValid & alertEn & eyeLow;
    strobe.srcClear        = srcRead;
  end
endmodule

// File: rtl/alert_datapath.sv
module alert_datapath
  import link_alert_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  srcStrobe_t         strobe,
  input  logic               pinEn,
  output logic [NUM_SRC-1:0] irqSrc,
  output logic               irqPinN
);
  logic [NUM_SRC-1:0] srcQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ <= '0;
    end else begin
      srcQ <= (strobe.srcClear ? '0 : srcQ) | strobe.srcSet;
    end
  end

  always_comb begin
    irqSrc  = srcQ;
    irqPinN = ~(pinEn & (|srcQ));
  end
endmodule

// File: rtl/link_alert_unit.sv
module link_alert_unit
  import link_alert_pkg::*;
#(
  parameter int NUM_IN    = 2,
  parameter int DEB_LEN   = 4,
  parameter int EYE_W     = 8,
  parameter int THR_W     = 4,
  parameter int THR_SHIFT = 2,
  localparam int SEL_W    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IN-1:0]  sdRaw,
  input  logic [NUM_IN-1:0]  sdForceOff,
  input  logic [SEL_W-1:0]   inSel,
  input  logic [EYE_W-1:0]   eyeWidth,
  input  logic               eyeValid,
  input  logic [THR_W-1:0]   eyeThresh,
  input  logic               alertEn,
  input  logic               pinEn,
  input  logic               srcRead,
  output logic [NUM_IN-1:0]  losStatus,
  output logic               rxPowerDown,
  output logic [NUM_SRC-1:0] irqSrc,
  output logic               irqPinN
);
  srcStrobe_t strobe;

  alert_ctrl #(
    .NUM_IN   (NUM_IN),
    .SEL_W    (SEL_W),
    .DEB_LEN  (DEB_LEN),
    .EYE_W    (EYE_W),
    .THR_W    (THR_W),
    .THR_SHIFT(THR_SHIFT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sdRaw      (sdRaw),
    .sdForceOff (sdForceOff),
    .inSel      (inSel),
    .eyeWidth   (eyeWidth),
    .eyeValid   (eyeValid),
    .eyeThresh  (eyeThresh),
    .alertEn    (alertEn),
    .srcRead    (srcRead),
    .losStatus  (losStatus),
    .rxPowerDown(rxPowerDown),
    .strobe     (strobe)
  );

  alert_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .pinEn  (pinEn),
    .irqSrc (irqSrc),
    .irqPinN(irqPinN)
  );
endmodule

// File: rtl/link_alert_chk.sv
module link_alert_chk #(
  parameter int NUM_IN    = 2,
  parameter int EYE_W     = 8,
  parameter int THR_W     = 4,
  parameter int THR_SHIFT = 2,
  parameter int SEL_W     = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] sdForceOff,
  input logic [SEL_W-1:0]  inSel,
  input logic [EYE_W-1:0]  eyeWidth,
  input logic              eyeValid,
  input logic [THR_W-1:0]  eyeThresh,
  input logic              alertEn,
  input logic              pinEn,
  input logic              srcRead,
  input logic [NUM_IN-1:0] losStatus,
  input logic              rxPowerDown,
  input logic [1:0]        irqSrc,
  input logic              irqPinN
);
  localparam int SCL_W = THR_W + THR_SHIFT;
  localparam int CMP_W = (EYE_W > SCL_W) ? EYE_W : SCL_W;

  logic atOrAbove;
  assign atOrAbove = CMP_W'(eyeWidth) >= CMP_W'({eyeThresh, {THR_SHIFT{1'b0}}});

  // R3: a forced input always reads as lost
  a_r3_force_reads_loss: assert property (@(posedge clk) disable iff (!rstN)
    sdForceOff[0] |-> losStatus[0]);

  // R4: power-down follows the selected input's status
  a_r4_pd_follows_sel: assert property (@(posedge clk) disable iff (!rstN)
    rxPowerDown == losStatus[inSel]);

  // R5: eye bit only rises after an enabled, valid measurement
  a_r5_eye_gated: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqSrc[1]) |-> $past(eyeValid && alertEn));

  // R5: a measurement at or above the scaled threshold does not set the bit
  a_r5_no_alert_above: assert property (@(posedge clk) disable iff (!rstN)
    (atOrAbove && !irqSrc[1]) |=> !irqSrc[1]);

  // R6: loss bit only rises when the selected input was lost
  a_r6_los_source: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqSrc[0]) |-> $past(rxPowerDown));

  // R6: source bits are sticky without a read
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (irqSrc[1] && !srcRead) |=> irqSrc[1]);

  // R7: a read with the loss condition absent clears the loss bit
  a_r7_clear_on_read: assert property (@(posedge clk) disable iff (!rstN)
    (srcRead && !rxPowerDown) |=> !irqSrc[0]);

  // R8: pin stays released while disabled or idle
  a_r8_pin_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!pinEn || irqSrc == 2'b00) |-> irqPinN);
endmodule

bind link_alert_unit link_alert_chk #(
  .NUM_IN   (NUM_IN),
  .EYE_W    (EYE_W),
  .THR_W    (THR_W),
  .THR_SHIFT(THR_SHIFT),
  .SEL_W    (SEL_W)
) u_chk (.*);

// File: tb/link_alert_unit_tb.sv
module link_alert_unit_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] sdRaw = 2'b00;
  logic [1:0] sdForceOff = 2'b00;
  logic [0:0] inSel = 1'b0;
  logic [7:0] eyeWidth = 8'd0;
  logic       eyeValid = 1'b0;
  logic [3:0] eyeThresh = 4'd0;
  logic       alertEn = 1'b0;
  logic       pinEn = 1'b1;
  logic       srcRead = 1'b0;
  logic [1:0] losStatus;
  logic       rxPowerDown;
  logic [1:0] irqSrc;
  logic       irqPinN;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_alert_unit u_dut (.*);

  // Behavioural reference: sample history, filtered levels, sticky sources
  logic [5:0] hist [2];
  logic [1:0] mFilt;
  logic [1:0] mSrc;

  always @(posedge clk) begin
    logic [1:0] losNow;
    logic       setLos, setEye;
    if (!rstN) begin
      hist[0] = '0; hist[1] = '0;
      mFilt = '0;
      mSrc = '0;
    end else begin
      losNow = ~mFilt | sdForceOff;
      setLos = losNow[inSel];
      setEye = eyeValid && alertEn && (int'(eyeWidth) < int'(eyeThresh) * 4);
      mSrc = (srcRead ? 2'b00 : mSrc) | {setEye, setLos};
      for (int i = 0; i < 2; i++) begin
        if (hist[i][4:1] == {4{~mFilt[i]}}) mFilt[i] = ~mFilt[i];
        hist[i] = {hist[i][4:0], sdRaw[i]};
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    logic [1:0] expLos;
    if (!done && rstN) begin
      expLos = ~mFilt | sdForceOff;
      check("R2/R3 losStatus", losStatus, expLos);
      check("R4 rxPowerDown", rxPowerDown, expLos[inSel]);
      check("R5/R6/R7 irqSrc", irqSrc, mSrc);
      check("R8 irqPinN", irqPinN, !(pinEn && mSrc != 2'b00));
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic eyeMeas(int w);
    eyeWidth = 8'(w);
    eyeValid = 1'b1;
    step(1);
    eyeValid = 1'b0;
  endtask

  task automatic readSrc();
    srcRead = 1'b1;
    step(1);
    srcRead = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    // R1 reset state
    check("R1 losStatus", losStatus, 3);
    check("R1 rxPowerDown", rxPowerDown, 1);
    check("R1 irqSrc", irqSrc, 0);
    check("R1 irqPinN", irqPinN, 1);
    rstN = 1'b1;
    step(3);

    // R2: input 0 comes up; exact latency checked against the model
    sdRaw = 2'b01;
    step(4);
    check("R2 status held before filter expires", losStatus[0], 1);
    step(2);
    check("R2 IN0 detected", losStatus[0], 0);
    check("R4 powered up", rxPowerDown, 0);
    readSrc();
    step(1);
    check("R7 loss bit cleared", irqSrc[0], 0);

    // R2: glitch on input 1 is filtered out
    sdRaw = 2'b11; step(3);
    sdRaw = 2'b01; step(8);
    check("R2 glitch ignored", losStatus[1], 1);

    // R2/R4: input 1 up, select it
    sdRaw = 2'b11; step(8);
    inSel = 1'b1; step(2);
    check("R2 IN1 detected", losStatus[1], 0);

    // R3: force-off on unselected input, then selected one
    sdForceOff = 2'b01; step(2);
    check("R3 forced IN0", losStatus[0], 1);
    check("R4 unselected force keeps power", rxPowerDown, 0);
    sdForceOff = 2'b10; step(2);
    check("R4 selected force powers down", rxPowerDown, 1);
    readSrc();
    check("R7 set wins over read", irqSrc[0], 1);
    sdForceOff = 2'b00; step(1);
    readSrc();
    step(1);
    check("R3 force released", losStatus, 0);
    check("R7 cleared after release", irqSrc, 0);

    // R5: eye alert around threshold 5 (scaled 20)
    pinEn = 1'b0;
    eyeThresh = 4'd5;
    alertEn = 1'b1;
    eyeMeas(20); step(1);
    check("R5 at threshold no alert", irqSrc[1], 0);
    eyeMeas(21); step(1);
    eyeWidth = 8'd3; step(2);
    check("R5 no strobe no alert", irqSrc[1], 0);
    alertEn = 1'b0;
    eyeMeas(0); step(1);
    check("R5 disabled no alert", irqSrc[1], 0);
    alertEn = 1'b1;
    eyeMeas(19); step(1);
    check("R5 below threshold alerts", irqSrc[1], 1);
    check("R8 pin disabled", irqPinN, 1);
    pinEn = 1'b1; step(1);
    check("R8 pin asserted", irqPinN, 0);
    step(4);
    check("R6 eye bit sticky", irqSrc[1], 1);
    readSrc();
    check("R7 eye bit cleared", irqSrc[1], 0);

    // R5: threshold extremes
    eyeThresh = 4'd0;
    eyeMeas(0); step(1);
    check("R5 zero threshold never alerts", irqSrc[1], 0);
    eyeThresh = 4'd15;
    eyeMeas(60); step(1);
    check("R5 width 60 vs 60", irqSrc[1], 0);
    eyeMeas(59); step(1);
    check("R5 width 59 vs 60", irqSrc[1], 1);
    srcRead = 1'b1; eyeWidth = 8'd10; eyeValid = 1'b1;
    step(1);
    srcRead = 1'b0; eyeValid = 1'b0;
    check("R7 eye set wins over read", irqSrc[1], 1);
    readSrc();

    // R2/R4/R6: selected input drops, loss bit and pin follow
    sdRaw = 2'b01; step(10);
    check("R2 IN1 lost", losStatus[1], 1);
    check("R6 loss recorded", irqSrc[0], 1);
    inSel = 1'b0; step(2);
    readSrc(); step(1);
    check("R7 cleared with IN0 selected", irqSrc, 0);
    check("R8 pin released", irqPinN, 1);
    step(3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule